// File: doc/BRIEF.md
# Reset Source Controller with Power-On Status Flag

This block merges every reset source of a chip into one system reset that is registered in the clock domain. The sources are a power-on request, an active-low external reset pin and a watchdog request. The external pin passes through a two-stage synchronizer and then a run-length filter, so that short low glitches never reach the reset tree. A configuration enable turns the pin's reset function off. The synchronized pin level then appears as an ordinary digital input.

After a power-on request, the reset stays asserted until the operating-condition input reports that supply, frequency and temperature are adequate. A watchdog request is stretched to a minimum reset length. Release is synchronous, and it trails the last active source by a fixed guard interval.

The block also keeps a software-visible power-on status flag, which is active-low and sticky. Power-on clears it. Software writes set it to 1, and software may also write it to 0. The pin and watchdog resets leave it untouched. The block never drives the pin.

Top module: `rstctl_top`

## Requirements
- R1: With the pin enable at 1, a pin low level that lasts at least FILT_LEN (default 4) consecutive clock cycles asserts sys_rst. sys_rst goes to 1 on the (FILT_LEN+3)th rising edge after pin_raw falls (two synchronizer stages, FILT_LEN filter samples, one output register).
- R2: With the pin enable at 1, a pin low pulse shorter than FILT_LEN cycles never asserts sys_rst.
- R3: With pin_en at 0, the pin never asserts sys_rst, and pin_din equals pin_raw as it was two rising edges earlier. With pin_en at 1, pin_din reads 1.
- R4: A rising edge with por_req at 1 sets por_flag to 0 and asserts sys_rst. This holds even if a software write of 1 happens in the same cycle.
- R5: Pin resets and watchdog resets leave por_flag unchanged.
- R6: A rising edge with sw_wr at 1 and por_req at 0 loads sw_wdata (0 or 1) into por_flag. Without such a write, por_flag never changes to 1.
- R7: After a power-on request, sys_rst stays at 1 in every cycle while cond_ok is 0.
- R8: A watchdog request sampled on an edge keeps sys_rst at 1 for at least WDT_LEN (default 8) cycles. A request held high extends the reset.
- R9: sys_rst falls only at a rising edge. It stays at 1 for REL_LEN+1 (default 3) cycles after every source has become inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on reset request, active high, sampled on the clock |
| pin_raw | input | 1 | Raw level of the external reset pin, active low, asynchronous |
| pin_en | input | 1 | Configuration: 1 gives the pin a reset function, 0 makes it a digital input |
| wdt_req | input | 1 | Watchdog reset request, active high |
| cond_ok | input | 1 | Operating conditions are met |
| sw_wr | input | 1 | Software write strobe for the status flag |
| sw_wdata | input | 1 | Value written to the status flag |
| sys_rst | output | 1 | Registered system reset, active high |
| pin_din | output | 1 | Synchronized pin level when the pin is a digital input, otherwise 1 |
| por_flag | output | 1 | Power-on status flag, 0 after a power-on |

## Verification
The functions that can meet in one cycle are the software write of the status flag and its clearing by a power-on request. A directed cycle raises sw_wr with sw_wdata at 1 in the same cycle as por_req. The expected flag is then 0, because the power-on clear takes priority. The randomized phase also lets writes land inside pin and watchdog resets, where the flag must still take the written value. Its expected state is computed by bench functions.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    typedef struct packed {
        logic por;
        logic pin;
        logic wdt;
    } src_vec_t;

    function automatic logic any_src(input src_vec_t s);
        return s.por | s.pin | s.wdt;
    endfunction

endpackage

// File: rtl/rstctl_pinflt.sv
module rstctl_pinflt #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic por_req,
    input  logic pin_raw,
    input  logic pin_en,
    output logic pin_trip,
    output logic pin_din
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [CW-1:0] cnt;
        logic          trip;
    } flt_state_t;

    flt_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_raw;
        st_d.s2 = st_q.s1;
        if (por_req) begin
            st_d.s1   = 1'b1;
            st_d.s2   = 1'b1;
            st_d.cnt  = '0;
            st_d.trip = 1'b0;
        end else if (!pin_en || st_q.s2) begin
            st_d.cnt  = '0;
            st_d.trip = 1'b0;
        end else begin
            if (st_q.cnt != CW'(FILT_LEN)) begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
            st_d.trip = (st_d.cnt == CW'(FILT_LEN));
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pin_trip = st_q.trip;
    assign pin_din  = pin_en ? 1'b1 : st_q.s2;

    assert_trip_needs_run_R2 : assert property (@(posedge clk) disable iff (por_req)
        $rose(st_q.trip) |-> $past(st_q.cnt == CW'(FILT_LEN - 1)));

    assert_disabled_no_trip_R3 : assert property (@(posedge clk) disable iff (por_req)
        !pin_en |=> !st_q.trip);

endmodule

// File: rtl/rstctl_stretch.sv
module rstctl_stretch #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic por_req,
    input  logic trig,
    output logic active
);
    localparam int WW = $clog2(LEN + 1);

    typedef struct packed {
        logic [WW-1:0] cnt;
    } str_state_t;

    str_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (por_req) begin
            st_d.cnt = '0;
        end else if (trig) begin
            st_d.cnt = WW'(LEN);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - WW'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign active = (st_q.cnt != '0);

    assert_wdt_loads_R8 : assert property (@(posedge clk) disable iff (por_req)
        trig |=> active);

endmodule

// File: rtl/rstctl_porflag.sv
module rstctl_porflag (
    input  logic clk,
    input  logic por_req,
    input  logic sw_wr,
    input  logic sw_wdata,
    output logic flag
);
    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (por_req) begin
            st_d.flag = 1'b0;
        end else if (sw_wr) begin
            st_d.flag = sw_wdata;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign flag = st_q.flag;

    assert_por_clears_R4 : assert property (@(posedge clk) disable iff (por_req)
        $fell(por_req) |-> !flag);

    assert_flag_holds_R5 : assert property (@(posedge clk) disable iff (por_req)
        !sw_wr |=> $stable(flag));

    assert_sw_write_R6 : assert property (@(posedge clk) disable iff (por_req)
        sw_wr |=> (flag == $past(sw_wdata)));

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top #(
    parameter int FILT_LEN = 4,
    parameter int WDT_LEN  = 8,
    parameter int REL_LEN  = 2
) (
    input  logic clk,
    input  logic por_req,
    input  logic pin_raw,
    input  logic pin_en,
    input  logic wdt_req,
    input  logic cond_ok,
    input  logic sw_wr,
    input  logic sw_wdata,
    output logic sys_rst,
    output logic pin_din,
    output logic por_flag
);
    import rstctl_pkg::*;

    localparam int RW = $clog2(REL_LEN + 1);

    typedef struct packed {
        logic          hold;
        logic [RW-1:0] rcnt;
        logic          rst;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       pin_trip;
    logic       wdt_act;
    logic       active;
    src_vec_t   src;

    rstctl_pinflt #(.FILT_LEN(FILT_LEN)) i_pinflt (
        .clk      (clk),
        .por_req  (por_req),
        .pin_raw  (pin_raw),
        .pin_en   (pin_en),
        .pin_trip (pin_trip),
        .pin_din  (pin_din)
    );

    rstctl_stretch #(.LEN(WDT_LEN)) i_wdt_stretch (
        .clk     (clk),
        .por_req (por_req),
        .trig    (wdt_req),
        .active  (wdt_act)
    );

    rstctl_porflag i_porflag (
        .clk      (clk),
        .por_req  (por_req),
        .sw_wr    (sw_wr),
        .sw_wdata (sw_wdata),
        .flag     (por_flag)
    );

    always_comb begin
        src.por = st_q.hold;
        src.pin = pin_trip;
        src.wdt = wdt_act;
        active  = any_src(src) | por_req;

        st_d      = st_q;
        st_d.hold = por_req | (st_q.hold & ~cond_ok);
        if (active) begin
            st_d.rcnt = RW'(REL_LEN);
        end else if (st_q.rcnt != '0) begin
            st_d.rcnt = st_q.rcnt - RW'(1);
        end
        st_d.rst = active | (st_q.rcnt != '0);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sys_rst = st_q.rst;

    assert_pin_resets_R1 : assert property (@(posedge clk) disable iff (por_req)
        pin_trip |=> sys_rst);

    assert_hold_keeps_rst_R7 : assert property (@(posedge clk) disable iff (por_req)
        st_q.hold |=> sys_rst);

    assert_release_gap_R9 : assert property (@(posedge clk) disable iff (por_req)
        $fell(sys_rst) |-> (!$past(active) && !$past(active, 2)));

endmodule

// File: tb/test_rstctl_top.sv
module test_rstctl_top;
    localparam int FILT_LEN = 4;
    localparam int WDT_LEN  = 8;
    localparam int REL_LEN  = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic por_req  = 1'b1;
    logic pin_raw  = 1'b1;
    logic pin_en   = 1'b1;
    logic wdt_req  = 1'b0;
    logic cond_ok  = 1'b0;
    logic sw_wr    = 1'b0;
    logic sw_wdata = 1'b0;
    logic sys_rst, pin_din, por_flag;

    rstctl_top #(.FILT_LEN(FILT_LEN), .WDT_LEN(WDT_LEN), .REL_LEN(REL_LEN)) i_rstctl_top (
        .clk(clk), .por_req(por_req), .pin_raw(pin_raw), .pin_en(pin_en),
        .wdt_req(wdt_req), .cond_ok(cond_ok), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .sys_rst(sys_rst), .pin_din(pin_din), .por_flag(por_flag)
    );

    int    vectors = 0;
    int    fails   = 0;
    bit    done    = 1'b0;
    string tag     = "R4";

    bit m_s1 = 1, m_s2 = 1, m_flt = 0, m_hold = 0, m_rst = 0, m_flag = 0;
    int m_cnt = 0, m_w = 0, m_r = 0;

    function automatic int count_down(input int v);
        return (v > 0) ? v - 1 : 0;
    endfunction

    function automatic bit exp_din(input bit en, input bit s2);
        return en ? 1'b1 : s2;
    endfunction

    task automatic model_edge();
        bit n_s1, n_s2, n_flt, act;
        int n_cnt, n_w;
        act   = por_req | m_hold | m_flt | (m_w != 0);
        n_s1  = pin_raw;
        n_s2  = m_s1;
        n_cnt = m_cnt;
        n_flt = m_flt;
        n_w   = m_w;
        if (por_req) begin
            n_s1 = 1; n_s2 = 1; n_cnt = 0; n_flt = 0; n_w = 0;
        end else begin
            if (!pin_en || m_s2) begin
                n_cnt = 0; n_flt = 0;
            end else begin
                n_cnt = (m_cnt < FILT_LEN) ? m_cnt + 1 : FILT_LEN;
                n_flt = (n_cnt == FILT_LEN);
            end
            n_w = wdt_req ? WDT_LEN : count_down(m_w);
        end
        m_rst  = act | (m_r != 0);
        m_r    = act ? REL_LEN : count_down(m_r);
        m_hold = por_req | (m_hold & !cond_ok);
        m_flag = por_req ? 1'b0 : (sw_wr ? sw_wdata : m_flag);
        m_s1 = n_s1; m_s2 = n_s2; m_cnt = n_cnt; m_flt = n_flt; m_w = n_w;
    endtask

    task automatic check(input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("sys_rst", sys_rst, m_rst);
        check("pin_din", pin_din, exp_din(pin_en, m_s2));
        check("por_flag", por_flag, m_flag);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic pin_pulse(input int len);
        pin_raw = 1'b0;
        steps(len);
        pin_raw = 1'b1;
        steps(FILT_LEN + 8);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd2024);
        // R4: power-on reset state, with the flag cleared
        tag = "R4";
        steps(3);
        check("reset_flag", por_flag, 1'b0);
        check("reset_rst", sys_rst, 1'b1);
        // R7: reset held while conditions are not met
        tag = "R7";
        por_req = 1'b0;
        steps(12);
        check("hold_rst", sys_rst, 1'b1);
        // R9: guard interval after release
        tag = "R9";
        cond_ok = 1'b1;
        steps(2);
        check("guard_rst", sys_rst, 1'b1);
        steps(6);
        check("released", sys_rst, 1'b0);
        // R6: software sets the flag
        tag = "R6";
        sw_wr = 1'b1; sw_wdata = 1'b1;
        step();
        sw_wr = 1'b0;
        check("flag_set", por_flag, 1'b1);
        // R2: short pulses
        tag = "R2";
        for (int l = 1; l < FILT_LEN; l++) begin
            pin_pulse(l);
            check("short_no_rst", sys_rst, 1'b0);
        end
        // R1: pulses of the filter length and longer
        tag = "R1";
        pin_raw = 1'b0;
        steps(FILT_LEN + 2);
        check("not_yet", sys_rst, 1'b0);
        step();
        check("trip_edge", sys_rst, 1'b1);
        pin_raw = 1'b1;
        steps(10);
        pin_pulse(FILT_LEN + 5);
        // R5: flag survives pin reset
        tag = "R5";
        check("flag_after_pin", por_flag, 1'b1);
        // R8: watchdog pulse and held request
        tag = "R8";
        wdt_req = 1'b1;
        step();
        wdt_req = 1'b0;
        steps(WDT_LEN);
        check("wdt_min", sys_rst, 1'b1);
        steps(6);
        wdt_req = 1'b1;
        steps(20);
        wdt_req = 1'b0;
        steps(14);
        tag = "R5";
        check("flag_after_wdt", por_flag, 1'b1);
        // R3: pin as digital input
        tag = "R3";
        pin_en = 1'b0;
        for (int i = 0; i < 200; i++) begin
            pin_raw = ($urandom_range(0, 3) != 0) ? 1'b0 : 1'b1;
            step();
        end
        check("no_rst_disabled", sys_rst, 1'b0);
        pin_raw = 1'b1;
        steps(3);
        pin_en = 1'b1;
        steps(4);
        // R4: write of 1 meets power-on in the same cycle
        tag = "R4";
        por_req = 1'b1; sw_wr = 1'b1; sw_wdata = 1'b1;
        step();
        sw_wr = 1'b0; por_req = 1'b0;
        check("por_beats_write", por_flag, 1'b0);
        steps(8);
        // R6: write of 0 accepted
        tag = "R6";
        sw_wr = 1'b1; sw_wdata = 1'b1;
        step();
        sw_wdata = 1'b0;
        step();
        sw_wr = 1'b0;
        check("flag_write0", por_flag, 1'b0);
        // R9: random mix of all sources
        tag = "R9";
        for (int i = 0; i < 4000; i++) begin
            por_req  = ($urandom_range(0, 299) == 0);
            cond_ok  = ($urandom_range(0, 3) != 0);
            wdt_req  = ($urandom_range(0, 79) == 0);
            sw_wr    = ($urandom_range(0, 9) == 0);
            sw_wdata = $urandom_range(0, 1);
            if ($urandom_range(0, 149) == 0) pin_en = ~pin_en;
            if ($urandom_range(0, 5) == 0) pin_raw = ~pin_raw;
            step();
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule